// File: doc/BRIEF.md
# Recency-Ordered Priority Match Dictionary

This block holds a table of 32-bit words, kept in order of most recent use. Every cycle it can take one 32-bit search word and compare it with all entries in parallel. One cycle later it reports three results: whether some entry equals the word in full, the lowest-numbered entry that does, and, for every entry, which of its four bytes equal the matching bytes of the search word. A downstream encoder can use the byte vector to find the best partial match. It can use the exported fill count to size the location field it emits.

A search can also carry an update request. When an update is applied, the searched word becomes entry 0 and the entries above it move down by one place. If the word was found, the old copy is taken out. If it was not found, the filled region grows by one and, when the table is full, the oldest entry falls off the end. Reset writes zero into every entry, so there are no valid bits. An all-zero search therefore matches an unused slot, and the priority rule picks the first zero at or after the filled region.

Top module: `mtf_cam_dict`

## Requirements
- R1: While `rst` is high at a clock edge, every entry becomes zero, `fill` becomes 0, `res_valid`, `res_hit`, `res_loc` and `res_bytes` become zero, and `in_ready` is low. After reset, `in_ready` is high and a search for a nonzero word misses.
- R2: A result appears one clock after the search is presented. `res_valid` equals the `in_valid` of the previous cycle. When that `in_valid` was low, `res_hit`, `res_loc` and `res_bytes` are all zero.
- R3: `res_hit` is 1 when at least one entry equals the search word in all 32 bits. `res_loc` is then the smallest index among the matching entries. On a miss `res_loc` is 0.
- R4: Bit 4*i+b of `res_bytes` is 1 when bits 8b+7..8b of entry i equal bits 8b+7..8b of the search word. Byte 0 is the least significant byte.
- R5: An update that hits at location L writes the word to entry 0 and moves entries 0..L-1 to 1..L. Entries above L keep their positions, and `fill` is unchanged.
- R6: An update that misses writes the word to entry 0 and moves entries 0..fill-1 down by one. `fill` then increases by one, up to DEPTH. When `fill` is already DEPTH, the last entry is discarded.
- R7: A search is matched against the table as it stood before any update applied at the same clock edge. That update is visible to the next search.
- R8: The table and `fill` change only when `in_valid` and `in_update` are both high. With `in_valid` low, `in_update` has no effect.
- R9: Entries that hold zero take part in matching like any other entry. After reset an all-zero search hits at location 0. With fill entries in use and zeros beneath them, it hits at location `fill`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Search word present this cycle |
| in_ready | output | 1 | High when a search is accepted (low during reset) |
| in_word | input | 32 | Search word, also the word inserted by an update |
| in_update | input | 1 | Apply the move-to-front update for this search |
| res_valid | output | 1 | Result registers hold a result |
| res_hit | output | 1 | Full 32-bit match found |
| res_loc | output | $clog2(DEPTH) | Lowest matching location |
| res_bytes | output | 4*DEPTH | Per-entry, per-byte equality vector |
| fill | output | $clog2(DEPTH+1) | Number of entries filled by updates |

## Verification
The hardest situation to reach is the saturated table. Only there does a missed update discard the oldest word instead of growing the filled region. The stimulus reaches it by inserting DEPTH+1 distinct nonzero words in a row. It then checks that the first word now misses, that the second sits at the last location, and that `fill` has stopped at DEPTH. Priority among zero slots is reached by searching for zero on a partly filled table, which must hit exactly at the boundary of the filled region.

// File: rtl/mtf_pkg.sv
package mtf_pkg;
  localparam int BYTE_W      = 8;
  localparam int ENTRY_BYTES = 4;
  localparam int WORD_W      = BYTE_W * ENTRY_BYTES;
endpackage

// File: rtl/mtf_cam_row.sv
module mtf_cam_row
  import mtf_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load,
  input  logic [WORD_W-1:0]      d,
  input  logic [WORD_W-1:0]      key,
  output logic [WORD_W-1:0]      q,
  output logic [ENTRY_BYTES-1:0] beq
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  for (genvar b = 0; b < ENTRY_BYTES; b++) begin : g_byte
    assign beq[b] = (q[b*BYTE_W +: BYTE_W] == key[b*BYTE_W +: BYTE_W]);
  end
endmodule

// File: rtl/mtf_prio_enc.sv
module mtf_prio_enc #(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/mtf_fill_ctr.sv
module mtf_fill_ctr #(
  parameter int MAX = 16,
  localparam int CW = $clog2(MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)                             count <= '0;
    else if (inc && count != CW'(MAX))   count <= count + 1'b1;
  end
endmodule

// File: rtl/mtf_cam_dict.sv
module mtf_cam_dict
  import mtf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH),
  localparam int FW = $clog2(DEPTH + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [WORD_W-1:0]            in_word,
  input  logic                         in_update,
  output logic                         res_valid,
  output logic                         res_hit,
  output logic [LW-1:0]                res_loc,
  output logic [ENTRY_BYTES*DEPTH-1:0] res_bytes,
  output logic [FW-1:0]                fill
);
  if (DEPTH != 16 && DEPTH != 32 && DEPTH != 64) begin : g_bad_depth
    $error("mtf_cam_dict: DEPTH must be 16, 32 or 64");
  end

  logic [WORD_W-1:0]            word_q [DEPTH];
  logic [WORD_W*DEPTH-1:0]      tab_flat;
  logic [ENTRY_BYTES*DEPTH-1:0] beq_all;
  logic [DEPTH-1:0]             full_eq;
  logic                         hit_now;
  logic [LW-1:0]                hit_idx;
  logic                         upd;
  logic [FW-1:0]                limit;

  assign upd      = in_valid && in_update;
  assign in_ready = !rst;

  // last location that takes part in the shift
  always_comb begin
    if (hit_now)              limit = FW'(hit_idx);
    else if (fill == FW'(DEPTH)) limit = FW'(DEPTH - 1);
    else                      limit = fill;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    logic [WORD_W-1:0] d_in;
    if (i == 0) begin : g_head
      assign d_in = in_word;
    end else begin : g_body
      assign d_in = word_q[i-1];
    end

    mtf_cam_row u_row (
      .clk  (clk),
      .rst  (rst),
      .load (upd && (FW'(i) <= limit)),
      .d    (d_in),
      .key  (in_word),
      .q    (word_q[i]),
      .beq  (beq_all[i*ENTRY_BYTES +: ENTRY_BYTES])
    );

    assign full_eq[i] = &beq_all[i*ENTRY_BYTES +: ENTRY_BYTES];
    assign tab_flat[i*WORD_W +: WORD_W] = word_q[i];
  end

  mtf_prio_enc #(.N(DEPTH)) u_prio (
    .req (full_eq),
    .any (hit_now),
    .idx (hit_idx)
  );

  mtf_fill_ctr #(.MAX(DEPTH)) u_fill (
    .clk   (clk),
    .rst   (rst),
    .inc   (upd && !hit_now),
    .count (fill)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_loc   <= '0;
      res_bytes <= '0;
    end else begin
      res_valid <= in_valid;
      res_hit   <= in_valid && hit_now;
      res_loc   <= (in_valid && hit_now) ? hit_idx : '0;
      res_bytes <= in_valid ? beq_all : '0;
    end
  end
endmodule

// File: rtl/mtf_cam_dict_chk.sv
module mtf_cam_dict_chk
  import mtf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH),
  localparam int FW = $clog2(DEPTH + 1)
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         in_valid,
  input logic                         in_update,
  input logic [WORD_W-1:0]            in_word,
  input logic                         res_valid,
  input logic                         res_hit,
  input logic [LW-1:0]                res_loc,
  input logic [ENTRY_BYTES*DEPTH-1:0] res_bytes,
  input logic [FW-1:0]                fill,
  input logic                         hit_now,
  input logic [WORD_W*DEPTH-1:0]      tab_flat
);
  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!res_hit && res_loc == '0 && fill == '0 && !res_valid));

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!res_valid && !res_hit && res_bytes == '0));

  p_hit_bytes_r3: assert property (@(posedge clk) disable iff (rst)
    res_hit |-> (res_bytes[res_loc*ENTRY_BYTES +: ENTRY_BYTES] == '1));

  p_miss_loc_r3: assert property (@(posedge clk) disable iff (rst)
    !res_hit |-> (res_loc == '0));

  p_front_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_update) |=> (tab_flat[WORD_W-1:0] == $past(in_word)));

  p_hit_fill_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_update && hit_now) |=> (fill == $past(fill)));

  p_fill_bound_r6: assert property (@(posedge clk) disable iff (rst)
    fill <= FW'(DEPTH));

  p_no_update_r8: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_update) |=> ($stable(tab_flat) && $stable(fill)));
endmodule

bind mtf_cam_dict mtf_cam_dict_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_update (in_update),
  .in_word   (in_word),
  .res_valid (res_valid),
  .res_hit   (res_hit),
  .res_loc   (res_loc),
  .res_bytes (res_bytes),
  .fill      (fill),
  .hit_now   (hit_now),
  .tab_flat  (tab_flat)
);

// File: tb/mtf_cam_dict_bench.sv
`timescale 1ns/1ps
module mtf_cam_dict_bench;
  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH);
  localparam int FW = $clog2(DEPTH + 1);

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic [31:0]          in_word = '0;
  logic                 in_update = 1'b0;
  logic                 res_valid;
  logic                 res_hit;
  logic [LW-1:0]        res_loc;
  logic [4*DEPTH-1:0]   res_bytes;
  logic [FW-1:0]        fill;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  mtf_cam_dict #(.DEPTH(DEPTH)) u_mtf_cam_dict (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_update(in_update), .res_valid(res_valid),
    .res_hit(res_hit), .res_loc(res_loc), .res_bytes(res_bytes), .fill(fill)
  );

  // {word, update, exp_hit, exp_loc, exp_fill, exp entry0 byte nibble}
  localparam int VW = 32 + 1 + 1 + 8 + 8 + 4;
  localparam int NV = 10;
  localparam logic [VW-1:0] VEC [NV] = '{
    {32'h11223344, 1'b1, 1'b0, 8'd0, 8'd1, 4'h0},
    {32'h55667788, 1'b1, 1'b0, 8'd0, 8'd2, 4'h0},
    {32'h99AABBCC, 1'b1, 1'b0, 8'd0, 8'd3, 4'h0},
    {32'h11223344, 1'b1, 1'b1, 8'd2, 8'd3, 4'h0},
    {32'h11223344, 1'b0, 1'b1, 8'd0, 8'd3, 4'hF},
    {32'h55667788, 1'b0, 1'b1, 8'd2, 8'd3, 4'h0},
    {32'h00000000, 1'b0, 1'b1, 8'd3, 8'd3, 4'h0},
    {32'h11223399, 1'b1, 1'b0, 8'd0, 8'd4, 4'hE},
    {32'h99AABBCC, 1'b1, 1'b1, 8'd2, 8'd4, 4'h0},
    {32'h55667788, 1'b0, 1'b1, 8'd3, 8'd4, 4'h0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // present one search for one cycle; return at the following falling edge
  task automatic step(input logic [31:0] w, input logic u);
    @(negedge clk);
    in_word   = w;
    in_update = u;
    in_valid  = 1'b1;
    @(posedge clk);
    #1;
    in_valid  = 1'b0;
    in_update = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 ready low in reset", 64'(in_ready), 64'd0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 hit after reset", 64'(res_hit), 64'd0);
    check("R1 loc after reset", 64'(res_loc), 64'd0);
    check("R1 fill after reset", 64'(fill), 64'd0);
    check("R1 ready low in reset", 64'(in_ready), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 ready after reset", 64'(in_ready), 64'd1);

    // table walk: R3 R4 R5 R6 R7 R9
    for (int k = 0; k < NV; k++) begin
      logic [VW-1:0] v;
      v = VEC[k];
      step(v[VW-1 -: 32], v[VW-33]);
      check($sformatf("R2 valid vec%0d", k), 64'(res_valid), 64'd1);
      check($sformatf("R3 hit vec%0d", k), 64'(res_hit), 64'(v[VW-34]));
      check($sformatf("R3 R5 loc vec%0d", k), 64'(res_loc), 64'(v[19:12]));
      check($sformatf("R5 R6 fill vec%0d", k), 64'(fill), 64'(v[11:4]));
      check($sformatf("R4 R7 bytes vec%0d", k), 64'(res_bytes[3:0]), 64'(v[3:0]));
    end

    // R2 R8: idle cycle carrying update does nothing
    @(negedge clk);
    in_word = 32'hDEADBEEF;
    in_update = 1'b1;
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_update = 1'b0;
    check("R2 idle valid", 64'(res_valid), 64'd0);
    check("R2 idle hit", 64'(res_hit), 64'd0);
    check("R8 fill unchanged", 64'(fill), 64'd4);
    step(32'hDEADBEEF, 1'b0);
    check("R8 word not inserted", 64'(res_hit), 64'd0);
    step(32'h99AABBCC, 1'b0);
    check("R8 head unchanged", 64'(res_loc), 64'd0);

    // R1: reset clears table
    do_reset();
    step(32'h99AABBCC, 1'b0);
    check("R1 cleared table misses", 64'(res_hit), 64'd0);
    check("R1 fill cleared", 64'(fill), 64'd0);

    // R9: zero search on empty table hits location 0
    step(32'h0, 1'b1);
    check("R9 zero hit", 64'(res_hit), 64'd1);
    check("R9 zero loc", 64'(res_loc), 64'd0);
    check("R9 R5 fill stays", 64'(fill), 64'd0);

    // R6: saturation and eviction
    do_reset();
    for (int k = 1; k <= DEPTH + 1; k++) begin
      step(32'h10000000 + 32'(k), 1'b1);
      check($sformatf("R6 miss ins%0d", k), 64'(res_hit), 64'd0);
      check($sformatf("R6 fill ins%0d", k), 64'(fill), 64'((k > DEPTH) ? DEPTH : k));
    end
    step(32'h10000001, 1'b0);
    check("R6 oldest dropped", 64'(res_hit), 64'd0);
    step(32'h10000002, 1'b0);
    check("R6 second at tail hit", 64'(res_hit), 64'd1);
    check("R6 second at tail loc", 64'(res_loc), 64'(DEPTH - 1));
    step(32'h10000000 + 32'(DEPTH + 1), 1'b0);
    check("R3 newest at head", 64'(res_loc), 64'd0);
    check("R4 head nibble", 64'(res_bytes[3:0]), 64'hF);
    step(32'h10000005, 1'b1);
    check("R5 hit in full table", 64'(res_loc), 64'(DEPTH - 4));
    check("R5 fill held at max", 64'(fill), 64'(DEPTH));
    step(32'h10000005, 1'b0);
    check("R5 moved to front", 64'(res_loc), 64'd0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule